// File: doc/BRIEF.md
# Odd-Length Serial Audio Reframer

This block takes a three-wire serial audio stream (bit clock, channel sync, data) whose frame lasts 49 bit clocks. The sync line is high for 24 of them and low for 25. Each channel holds a 16-bit two's complement sample, sent MSB first in the first 16 bit periods after a sync transition. The block rebuilds these samples into a regular 64-slot left-justified stream, which a downstream digital audio transmitter can accept. That output stream is timed entirely from a 256·fs master clock, and the source and the master clock are not locked to each other.

The three input wires are oversampled by the master clock through synchronizers. Bits are taken on detected edges of the synchronized bit clock. By default this is the falling edge, and a parameter selects the rising edge instead. Every input phase length is checked. A complete left/right pair passes through a one-deep handoff register to the output generator. At each output frame boundary the generator loads a fresh pair if one is waiting, and otherwise sends the previous pair again.

Top module: `audio_reframer`

## Requirements
- R1: While reset is asserted, out_bclk is 0, out_lrck is 1, out_dat is 0, frame_err is 0 and pair_ready is 0.
- R2: out_bclk has a period of exactly 4 master clocks: high for 2 and low for 2.
- R3: out_lrck is high for the 32 output bit periods that carry the left channel and low for the next 32. It changes only together with a falling edge of out_bclk.
- R4: In each 32-slot half, slots 0 to 15 carry that channel's sample MSB first, and slots 16 to 31 carry 0. out_dat changes only together with a falling edge of out_bclk, so it is stable at every rising edge.
- R5: On input, a high sync marks the left channel. The sample is the 16 bits taken on the first 16 capture edges (falling by default) after a sync transition. Bits on later edges of that phase, including the last one, have no effect on the output.
- R6: Sample words go to the output bit for bit, with no change of sign or coding (for example 0x8000 and 0x7FFF come out unchanged).
- R7: A pair made of a left phase and the right phase after it appears on the output in a later frame. Pairs appear in input order, and none is lost when the input frame rate is at or below the output frame rate.
- R8: If no new pair is waiting at an output frame start, the previous pair is sent again and the output keeps running.
- R9: A left phase that is not 24 capture edges long, or a right phase that is not 25 long, sets frame_err. frame_err stays set until reset, and the pair containing that phase never appears on the output.
- R10: pair_ready rises when a checked pair is stored and falls only when the output side loads that pair at a frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | 256·fs master clock; clocks all logic |
| rst_n | input | 1 | Active-low reset, synchronous to mclk |
| in_bclk | input | 1 | Input bit clock, asynchronous |
| in_lrs | input | 1 | Input channel sync, high = left |
| in_dat | input | 1 | Input serial data |
| out_bclk | output | 1 | Output bit clock, mclk/4 |
| out_lrck | output | 1 | Output LR clock, high = left |
| out_dat | output | 1 | Output left-justified data |
| frame_err | output | 1 | Sticky input framing error |
| pair_ready | output | 1 | A pair waits in the handoff register |

## Verification
A phase counter in the wrong state shows up as frame_err within one input frame (49 input bit clocks), and every later pair is then missing from the output. A slot or divider fault on the output side shows up on out_lrck or on the bclk period within one 64-slot output frame. A handoff flag stuck at 1 or 0 shows as pairs sent out of order, or as endless repeats of one pair, in the first output frame after the next input pair arrives.

// File: rtl/reframer_pkg.sv
package reframer_pkg;

    // Sample width shared by the capture, handoff and emit sides.
    parameter int unsigned SMP_W = 16;

    typedef struct packed {
        logic [SMP_W-1:0] left;
        logic [SMP_W-1:0] right;
    } pair_t;

endpackage

// File: rtl/rf_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous single-bit inputs.
module rf_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef logic [STAGES-1:0][W-1:0] chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rf_capture.sv
// Edge-driven capture of the asymmetric input frame, phase length check,
// and pair assembly.
module rf_capture
    import reframer_pkg::*;
#(
    parameter int unsigned HI_LEN       = 24,
    parameter int unsigned LO_LEN       = 25,
    parameter bit          CAPTURE_FALL = 1'b1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  bclk,
    input  logic  lrs,
    input  logic  dat,
    output logic  push,
    output pair_t push_pair,
    output logic  err
);
    localparam int unsigned MAX_LEN = (HI_LEN > LO_LEN) ? HI_LEN : LO_LEN;
    localparam int unsigned CNT_W   = $clog2(MAX_LEN + 2) + 1;

    typedef struct packed {
        logic             bclk_prev;
        logic             armed;
        logic             started;
        logic             lrs_prev;
        logic [CNT_W-1:0] cnt;
        logic [SMP_W-1:0] shreg;
        logic [SMP_W-1:0] left_smp;
        logic             left_ok;
        logic             err;
        logic             push;
        pair_t            pair;
    } cap_t;

    cap_t cap_d, cap_q;

    logic             cap_edge;
    logic             len_ok;
    logic [SMP_W-1:0] shifted;

    always_comb begin
        cap_d           = cap_q;
        cap_d.push      = 1'b0;
        cap_d.bclk_prev = bclk;
        len_ok          = 1'b0;
        cap_edge        = CAPTURE_FALL ? (cap_q.bclk_prev & ~bclk)
                                       : (~cap_q.bclk_prev & bclk);
        shifted         = {cap_q.shreg[SMP_W-2:0], dat};

        if (cap_edge) begin
            cap_d.armed    = 1'b1;
            cap_d.lrs_prev = lrs;
            if (cap_q.armed && (lrs != cap_q.lrs_prev)) begin
                // Phase boundary: judge the phase that just ended.
                len_ok = cap_q.lrs_prev ? (cap_q.cnt == CNT_W'(HI_LEN))
                                        : (cap_q.cnt == CNT_W'(LO_LEN));
                if (cap_q.started) begin
                    if (!len_ok) cap_d.err = 1'b1;
                    if (cap_q.lrs_prev) begin
                        cap_d.left_smp = cap_q.shreg;
                        cap_d.left_ok  = len_ok;
                    end else begin
                        if (len_ok && cap_q.left_ok) begin
                            cap_d.push       = 1'b1;
                            cap_d.pair.left  = cap_q.left_smp;
                            cap_d.pair.right = cap_q.shreg;
                        end
                        cap_d.left_ok = 1'b0;
                    end
                end
                cap_d.started = 1'b1;
                cap_d.cnt     = CNT_W'(1);
                cap_d.shreg   = shifted;
            end else if (cap_q.started) begin
                if (cap_q.cnt != '1) cap_d.cnt = cap_q.cnt + 1'b1;
                if (cap_q.cnt < CNT_W'(SMP_W)) cap_d.shreg = shifted;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign push      = cap_q.push;
    assign push_pair = cap_q.pair;
    assign err       = cap_q.err;
endmodule

// File: rtl/rf_handoff.sv
// One-deep pair register between capture and emit.
module rf_handoff
    import reframer_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push,
    input  pair_t push_pair,
    input  logic  take,
    output logic  valid,
    output pair_t pair
);
    typedef struct packed {
        logic  valid;
        pair_t pair;
    } hand_t;

    hand_t hand_d, hand_q;

    always_comb begin
        hand_d = hand_q;
        if (take) hand_d.valid = 1'b0;
        if (push) begin
            hand_d.valid = 1'b1;
            hand_d.pair  = push_pair;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hand_q <= '0;
        else        hand_q <= hand_d;
    end

    assign valid = hand_q.valid;
    assign pair  = hand_q.pair;
endmodule

// File: rtl/rf_emit.sv
// Output frame generator: mclk divider, slot counter, left-justified data.
module rf_emit
    import reframer_pkg::*;
#(
    parameter int unsigned SLOTS = 32,
    parameter int unsigned DIV   = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_valid,
    input  pair_t in_pair,
    output logic  take,
    output logic  out_bclk,
    output logic  out_lrck,
    output logic  out_dat
);
    localparam int unsigned DIV_W  = $clog2(DIV);
    localparam int unsigned SLOT_W = $clog2(2 * SLOTS);
    localparam int unsigned IDX_W  = SLOT_W - 1;
    localparam int unsigned LAST   = 2 * SLOTS - 1;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [SLOT_W-1:0] slot;
        pair_t             cur;
        logic              bclk;
        logic              lrck;
        logic              dat;
    } emit_t;

    emit_t emit_d, emit_q;

    logic             tick;
    logic             half;
    logic [IDX_W-1:0] idx;
    logic [SMP_W-1:0] smp;

    always_comb begin
        emit_d = emit_q;
        tick   = (emit_q.div == DIV_W'(DIV - 1));
        take   = tick && (emit_q.slot == SLOT_W'(LAST)) && in_valid;

        emit_d.div  = tick ? '0 : emit_q.div + 1'b1;
        emit_d.slot = tick ? emit_q.slot + 1'b1 : emit_q.slot;
        if (take) emit_d.cur = in_pair;

        half = emit_d.slot[SLOT_W-1];
        idx  = emit_d.slot[IDX_W-1:0];
        smp  = half ? emit_d.cur.right : emit_d.cur.left;

        emit_d.bclk = (emit_d.div >= DIV_W'(DIV / 2));
        emit_d.lrck = ~half;
        emit_d.dat  = (idx < IDX_W'(SMP_W)) ? smp[SMP_W - 1 - int'(idx)] : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            emit_q      <= '0;
            emit_q.lrck <= 1'b1;
        end else begin
            emit_q <= emit_d;
        end
    end

    assign out_bclk = emit_q.bclk;
    assign out_lrck = emit_q.lrck;
    assign out_dat  = emit_q.dat;
endmodule

// File: rtl/audio_reframer.sv
module audio_reframer #(
    parameter int unsigned HI_LEN       = 24,
    parameter int unsigned LO_LEN       = 25,
    parameter int unsigned SLOTS        = 32,
    parameter int unsigned MCLK_DIV     = 4,
    parameter int unsigned SYNC_STAGES  = 2,
    parameter bit          CAPTURE_FALL = 1'b1
) (
    input  logic mclk,
    input  logic rst_n,
    input  logic in_bclk,
    input  logic in_lrs,
    input  logic in_dat,
    output logic out_bclk,
    output logic out_lrck,
    output logic out_dat,
    output logic frame_err,
    output logic pair_ready
);
    import reframer_pkg::*;

    logic [2:0] sig_s;
    logic       cap_push;
    pair_t      cap_pair;
    logic       hand_take;
    pair_t      hand_pair;

    rf_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (mclk),
        .rst_n (rst_n),
        .d     ({in_bclk, in_lrs, in_dat}),
        .q     (sig_s)
    );

    rf_capture #(.HI_LEN(HI_LEN), .LO_LEN(LO_LEN), .CAPTURE_FALL(CAPTURE_FALL)) i_cap (
        .clk       (mclk),
        .rst_n     (rst_n),
        .bclk      (sig_s[2]),
        .lrs       (sig_s[1]),
        .dat       (sig_s[0]),
        .push      (cap_push),
        .push_pair (cap_pair),
        .err       (frame_err)
    );

    rf_handoff i_hand (
        .clk       (mclk),
        .rst_n     (rst_n),
        .push      (cap_push),
        .push_pair (cap_pair),
        .take      (hand_take),
        .valid     (pair_ready),
        .pair      (hand_pair)
    );

    rf_emit #(.SLOTS(SLOTS), .DIV(MCLK_DIV)) i_emit (
        .clk      (mclk),
        .rst_n    (rst_n),
        .in_valid (pair_ready),
        .in_pair  (hand_pair),
        .take     (hand_take),
        .out_bclk (out_bclk),
        .out_lrck (out_lrck),
        .out_dat  (out_dat)
    );
endmodule

// File: rtl/reframer_chk.sv
module reframer_chk (
    input logic clk,
    input logic rst_n,
    input logic out_bclk,
    input logic out_lrck,
    input logic out_dat,
    input logic frame_err,
    input logic pair_ready,
    input logic take
);
    // R2
    bclk_high_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_bclk) |=> out_bclk);

    // R2
    bclk_low_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_bclk) |=> !out_bclk);

    // R3
    lrck_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_lrck) |-> $fell(out_bclk));

    // R4
    dat_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_dat) |-> $fell(out_bclk));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> frame_err);

    // R10
    ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pair_ready) |-> $past(take));
endmodule

bind audio_reframer reframer_chk i_chk (
    .clk        (mclk),
    .rst_n      (rst_n),
    .out_bclk   (out_bclk),
    .out_lrck   (out_lrck),
    .out_dat    (out_dat),
    .frame_err  (frame_err),
    .pair_ready (pair_ready),
    .take       (hand_take)
);

// File: tb/test_audio_reframer.sv
`timescale 1ns/1ps
module test_audio_reframer;
    logic mclk = 1'b0;
    logic rst_n = 1'b0;
    logic in_bclk = 1'b0, in_lrs = 1'b0, in_dat = 1'b0;
    logic out_bclk, out_lrck, out_dat, frame_err, pair_ready;

    audio_reframer i_audio_reframer (
        .mclk(mclk), .rst_n(rst_n), .in_bclk(in_bclk), .in_lrs(in_lrs), .in_dat(in_dat),
        .out_bclk(out_bclk), .out_lrck(out_lrck), .out_dat(out_dat),
        .frame_err(frame_err), .pair_ready(pair_ready)
    );

    always #4 mclk = ~mclk;

    localparam realtime HALF = 21.0;

    int total = 0, bad = 0;
    logic [31:0] exp_q[$];
    logic [31:0] last_pair = '0;
    int rep_cnt = 0, rdy_seen = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- driver ----------------
    task automatic send_bit(input bit lr, input bit b);
        in_bclk = 1'b1; in_lrs = lr; in_dat = b;
        #(HALF);
        in_bclk = 1'b0;
        #(HALF);
    endtask

    task automatic send_frame(input logic [15:0] l, input logic [15:0] r,
                              input int hi, input int lo, input bit expect_out);
        if (expect_out) exp_q.push_back({l, r});
        for (int i = 0; i < hi; i++)
            send_bit(1'b1, (i < 16) ? l[15-i] : ((i == hi-1) ? 1'b1 : 1'($urandom)));
        for (int i = 0; i < lo; i++)
            send_bit(1'b0, (i < 16) ? r[15-i] : ((i == lo-1) ? 1'b1 : 1'($urandom)));
    endtask

    // ---------------- monitor / scoreboard ----------------
    logic        prev_b = 1'b0, prev_lr = 1'b0, collecting = 1'b0, have_rise = 1'b0;
    logic        per_bad = 1'b0, lr_bad = 1'b0;
    int          bitn = 0, since_rise = 0, hi_cnt = 0;
    logic [63:0] frm;

    task automatic eval_frame();
        logic [15:0] l, pl, r, pr;
        l = frm[63:48]; pl = frm[47:32]; r = frm[31:16]; pr = frm[15:0];
        chk(pl == 0 && pr == 0, "R4", "unused slots", {pl, pr}, 0);
        chk(!lr_bad, "R3", "lrck slot pattern", lr_bad, 0);
        chk(!per_bad, "R2", "bclk period", per_bad, 0);
        lr_bad = 1'b0; per_bad = 1'b0;
        if (exp_q.size() > 0 && {l, r} == exp_q[0]) begin
            chk(1'b1, "R7", "new pair", {l, r}, exp_q[0]);
            last_pair = exp_q.pop_front();
        end else if ({l, r} == last_pair) begin
            if (last_pair != 0) rep_cnt++;
            chk(1'b1, "R8", "repeat pair", {l, r}, last_pair);
        end else begin
            chk(1'b0, "R5 R6 R7", "frame pair", {l, r},
                (exp_q.size() > 0) ? exp_q[0] : last_pair);
        end
    endtask

    always @(negedge mclk) begin
        if (rst_n) begin
            since_rise++;
            if (pair_ready) rdy_seen++;
            if (out_bclk) hi_cnt++;
            if (!out_bclk && prev_b) begin
                if (hi_cnt != 2) per_bad = 1'b1;
                hi_cnt = 0;
            end
            if (out_bclk && !prev_b) begin
                if (have_rise && since_rise != 4) per_bad = 1'b1;
                have_rise = 1'b1; since_rise = 0;
                if (out_lrck && !prev_lr) begin collecting = 1'b1; bitn = 0; end
                if (collecting) begin
                    frm[63-bitn] = out_dat;
                    if (out_lrck != (bitn < 32)) lr_bad = 1'b1;
                    bitn++;
                    if (bitn == 64) begin eval_frame(); collecting = 1'b0; end
                end
                prev_lr = out_lrck;
            end
            prev_b = out_bclk;
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge mclk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge mclk);
        // R1 reset state
        chk(out_bclk == 0, "R1", "out_bclk in reset", out_bclk, 0);
        chk(out_lrck == 1, "R1", "out_lrck in reset", out_lrck, 1);
        chk(out_dat == 0, "R1", "out_dat in reset", out_dat, 0);
        chk(frame_err == 0, "R1", "frame_err in reset", frame_err, 0);
        chk(pair_ready == 0, "R1", "pair_ready in reset", pair_ready, 0);
        rst_n = 1'b1;
        #100;
        for (int i = 0; i < 4; i++) send_bit(1'b0, 1'b0);

        // R6 extremes and R5 stray trailing bits, directed patterns
        send_frame(16'h8000, 16'h7FFF, 24, 25, 1'b1);
        send_frame(16'hFFFF, 16'h0001, 24, 25, 1'b1);
        send_frame(16'h1234, 16'hABCD, 24, 25, 1'b1);
        send_frame(16'hA5A5, 16'h5A5A, 24, 25, 1'b1);
        repeat (4) @(negedge mclk);
        chk(frame_err == 0, "R9", "no error on good frames", frame_err, 0);

        // R8: input pauses, output must keep repeating
        #6000;
        send_frame(16'h0F0F, 16'hF0F0, 24, 25, 1'b1);

        // R9: short left phase
        send_frame(16'hDEAD, 16'hBEEF, 23, 25, 1'b0);
        repeat (8) @(negedge mclk);
        chk(frame_err == 1, "R9", "short left phase flagged", frame_err, 1);
        send_frame(16'h1111, 16'h2222, 24, 25, 1'b1);
        // R9: long right phase
        send_frame(16'hCAFE, 16'hF00D, 24, 26, 1'b0);
        send_frame(16'h3333, 16'h4444, 24, 25, 1'b1);

        for (int k = 0; k < 12; k++) begin
            logic [31:0] v;
            v = $urandom | 32'h0001_0001;
            send_frame(v[31:16], v[15:0], 24, 25, 1'b1);
        end
        // trailing frame closes the last expected pair; its own pair never completes
        send_frame(16'h7777, 16'h8888, 24, 25, 1'b0);
        #8000;
        @(negedge mclk);

        chk(exp_q.size() == 0, "R7", "pairs still undelivered", exp_q.size(), 0);
        chk(rep_cnt > 0, "R8", "repeated nonzero frames", rep_cnt, 1);
        chk(rdy_seen > 0, "R10", "pair_ready seen high", rdy_seen, 1);
        chk(pair_ready == 0, "R10", "pair_ready after drain", pair_ready, 0);
        chk(frame_err == 1, "R9", "frame_err sticky", frame_err, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule